// File: doc/BRIEF.md
# Accumulator Field Rotate Unit

This block performs a one-bit rotate through carry on the 24-bit middle field of one of two 56-bit accumulators. Each accumulator has three parts: an 8-bit extension in bits 55..48, a 24-bit middle field in bits 47..24, and a 24-bit low field in bits 23..0. Only the middle field moves. The extension and low fields of the chosen accumulator keep their values, and so does the other accumulator. The carry flag held in the block's flag register supplies the bit that enters the field. The bit that leaves the field becomes the new carry.

A start strobe carries three things: a destination select bit, a direction bit, and a limit-hit indication from a parallel move that runs at the same time. The block then raises `busy` for one cycle. On the next edge it writes the rotated accumulator and the new flags, and pulses `done`. The result is therefore valid at the end of the second cycle. Both accumulators and the 8-bit flag register are held inside the block. They can be preloaded through load ports while the block is idle, which sets up operands and the incoming carry.

Top module: `accum_field_rotator`

## Requirements
- R1: After synchronous reset, both accumulators and the flag register are zero, and `busy` and `done` are low.
- R2: With `rot_right`=0 (left), result bits 47..25 take old bits 46..24, result bit 24 takes the old carry, and the new carry is old bit 47.
- R3: With `rot_right`=1 (right), result bits 46..24 take old bits 47..25, result bit 47 takes the old carry, and the new carry is old bit 24.
- R4: Bits 55..48 and 23..0 of the destination accumulator are unchanged by an operation. The non-destination accumulator is unchanged entirely.
- R5: `dst_sel`=0 targets accumulator A (`acc_a`) and `dst_sel`=1 targets accumulator B (`acc_b`).
- R6: Flag N (flags bit 3) equals result bit 47. Flag Z (flags bit 2) is 1 exactly when result bits 47..24 are all zero, whatever the extension and low fields hold.
- R7: Flag V (flags bit 1) is cleared by every operation. Flag C (flags bit 0) receives the bit rotated out of the field.
- R8: Flag L (flags bit 6) becomes old L OR `limit_hit`, so it is sticky. Flags U (bit 4), E (bit 5) and S (bit 7) keep their previous values.
- R9: A start sampled while idle makes `busy` high after that edge. On the following edge the results are written, `busy` falls and `done` is high for exactly one cycle.
- R10: While `busy` is high, `start`, `acc_load` and `flag_load` have no effect.
- R11: While idle with `start` low, `acc_load` writes `acc_load_val` into the accumulator picked by `acc_load_sel`, and `flag_load` writes `flag_load_val` into the flags. Both take effect on that edge.
- R12: A left rotate of an all-zero accumulator with C=1 gives middle field 0x000001 and C=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a rotate (sampled when idle) |
| dst_sel | input | 1 | Destination: 0 = A, 1 = B |
| rot_right | input | 1 | Direction: 0 = left, 1 = right |
| limit_hit | input | 1 | Data limiting reported by the concurrent move |
| acc_load | input | 1 | Load an accumulator (idle only) |
| acc_load_sel | input | 1 | Accumulator to load: 0 = A, 1 = B |
| acc_load_val | input | 56 | Value to load |
| flag_load | input | 1 | Load the flag register (idle only) |
| flag_load_val | input | 8 | Flag value to load |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is written |
| acc_a | output | 56 | Accumulator A contents |
| acc_b | output | 56 | Accumulator B contents |
| flags | output | 8 | Flags: C0 V1 Z2 N3 U4 E5 L6 S7 |

## Verification
A fault in the latched destination or direction would show on the very cycle `done` rises. The wrong accumulator or the wrong middle-field bits would change, or carry would take the wrong end bit. The sweep compares both accumulators and all eight flags at that cycle. A corrupted sequencer state would show within one cycle as a `busy` longer than one cycle, a missing `done`, or a restart taken during `busy`. A loss of sticky-flag state would show at the next operation whose limit input is low.

// File: rtl/arot_pkg.sv
package arot_pkg;
  localparam int FLAG_W = 8;
  localparam int FC = 0;
  localparam int FV = 1;
  localparam int FZ = 2;
  localparam int FN = 3;
  localparam int FU = 4;
  localparam int FE = 5;
  localparam int FL = 6;
  localparam int FS = 7;

  typedef enum logic {
    ROT_LEFT  = 1'b0,
    ROT_RIGHT = 1'b1
  } rot_dir_e;

  typedef struct packed {
    rot_dir_e dir;
    logic     dst;
    logic     lim;
  } rot_req_t;
endpackage

// File: rtl/arot_field_rot.sv
module arot_field_rot #(
  parameter int W = 24
) (
  input  logic [W-1:0]       fld_i,
  input  logic               cin_i,
  input  arot_pkg::rot_dir_e dir_i,
  output logic [W-1:0]       fld_o,
  output logic               cout_o
);
  logic [W-1:0] up_w;
  logic [W-1:0] dn_w;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lo
        assign up_w[i] = cin_i;
      end else begin : g_lo_n
        assign up_w[i] = fld_i[i-1];
      end
      if (i == W-1) begin : g_hi
        assign dn_w[i] = cin_i;
      end else begin : g_hi_n
        assign dn_w[i] = fld_i[i+1];
      end
    end
  endgenerate

  always_comb begin
    if (dir_i == arot_pkg::ROT_LEFT) begin
      fld_o  = up_w;
      cout_o = fld_i[W-1];
    end else begin
      fld_o  = dn_w;
      cout_o = fld_i[0];
    end
  end
endmodule

// File: rtl/arot_acc_bank.sv
module arot_acc_bank #(
  parameter int NUM_ACC = 2,
  parameter int W       = 56,
  parameter int IDX_W   = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [W-1:0]                wr_val,
  output logic [NUM_ACC-1:0][W-1:0]   acc_o
);
  generate
    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
      always_ff @(posedge clk) begin
        if (rst) begin
          acc_o[g] <= '0;
        end else if (wr_en && (wr_idx == IDX_W'(g))) begin
          acc_o[g] <= wr_val;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/arot_ctrl.sv
module arot_ctrl (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               dst_i,
  input  arot_pkg::rot_dir_e dir_i,
  input  logic               lim_i,
  output logic               busy_o,
  output logic               done_o,
  output arot_pkg::rot_req_t req_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      req_o  <= '0;
    end else begin
      done_o <= busy_o;
      if (busy_o) begin
        busy_o <= 1'b0;
      end else if (start_i) begin
        busy_o    <= 1'b1;
        req_o.dir <= dir_i;
        req_o.dst <= dst_i;
        req_o.lim <= lim_i;
      end
    end
  end
endmodule

// File: rtl/accum_field_rotator.sv
module accum_field_rotator #(
  parameter int EXT_W = 8,
  parameter int MID_W = 24,
  parameter int LOW_W = 24
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                start,
  input  logic                                dst_sel,
  input  logic                                rot_right,
  input  logic                                limit_hit,
  input  logic                                acc_load,
  input  logic                                acc_load_sel,
  input  logic [EXT_W+MID_W+LOW_W-1:0]        acc_load_val,
  input  logic                                flag_load,
  input  logic [arot_pkg::FLAG_W-1:0]         flag_load_val,
  output logic                                busy,
  output logic                                done,
  output logic [EXT_W+MID_W+LOW_W-1:0]        acc_a,
  output logic [EXT_W+MID_W+LOW_W-1:0]        acc_b,
  output logic [arot_pkg::FLAG_W-1:0]         flags
);
  import arot_pkg::*;

  localparam int ACC_W  = EXT_W + MID_W + LOW_W;
  localparam int MID_LO = LOW_W;
  localparam int MID_HI = LOW_W + MID_W - 1;

  rot_req_t               req;
  logic                   dst_q;
  logic                   lim_q;
  logic [1:0][ACC_W-1:0]  bank_q;
  logic [ACC_W-1:0]       cur_acc;
  logic [ACC_W-1:0]       res_acc;
  logic [MID_W-1:0]       rot_fld;
  logic                   rot_cout;
  logic [FLAG_W-1:0]      flags_q;
  logic [FLAG_W-1:0]      flags_nx;
  logic                   idle_ld;
  logic                   wr_en;
  logic                   wr_idx;
  logic [ACC_W-1:0]       wr_val;

  arot_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .dst_i   (dst_sel),
    .dir_i   (rot_dir_e'(rot_right)),
    .lim_i   (limit_hit),
    .busy_o  (busy),
    .done_o  (done),
    .req_o   (req)
  );

  assign dst_q   = req.dst;
  assign lim_q   = req.lim;
  assign cur_acc = bank_q[dst_q];

  arot_field_rot #(.W(MID_W)) u_rot (
    .fld_i  (cur_acc[MID_HI:MID_LO]),
    .cin_i  (flags_q[FC]),
    .dir_i  (req.dir),
    .fld_o  (rot_fld),
    .cout_o (rot_cout)
  );

  always_comb begin
    res_acc                = cur_acc;
    res_acc[MID_HI:MID_LO] = rot_fld;
  end

  always_comb begin
    flags_nx     = flags_q;
    flags_nx[FC] = rot_cout;
    flags_nx[FV] = 1'b0;
    flags_nx[FZ] = ~|rot_fld;
    flags_nx[FN] = rot_fld[MID_W-1];
    flags_nx[FL] = flags_q[FL] | req.lim;
  end

  assign idle_ld = !busy && !start;
  assign wr_en   = busy || (acc_load && idle_ld);
  assign wr_idx  = busy ? dst_q : acc_load_sel;
  assign wr_val  = busy ? res_acc : acc_load_val;

  arot_acc_bank #(.NUM_ACC(2), .W(ACC_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_val (wr_val),
    .acc_o  (bank_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (busy) begin
      flags_q <= flags_nx;
    end else if (flag_load && idle_ld) begin
      flags_q <= flag_load_val;
    end
  end

  assign acc_a = bank_q[0];
  assign acc_b = bank_q[1];
  assign flags = flags_q;
endmodule

// File: rtl/arot_chk.sv
module arot_chk #(
  parameter int EXT_W = 8,
  parameter int MID_W = 24,
  parameter int LOW_W = 24
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          start,
  input logic                          flag_load,
  input logic                          acc_load,
  input logic                          busy,
  input logic                          done,
  input logic                          dst_q,
  input logic                          lim_q,
  input logic [EXT_W+MID_W+LOW_W-1:0]  acc_a,
  input logic [EXT_W+MID_W+LOW_W-1:0]  acc_b,
  input logic [arot_pkg::FLAG_W-1:0]   flags
);
  import arot_pkg::*;
  localparam int ACC_W  = EXT_W + MID_W + LOW_W;
  localparam int MID_LO = LOW_W;

  logic [MID_W-1:0] dmid;
  assign dmid = dst_q ? acc_b[MID_LO +: MID_W] : acc_a[MID_LO +: MID_W];

  // R9
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R9
  single_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done && !busy));
  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R4
  ext_low_keep_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(acc_a[ACC_W-1 -: EXT_W]) && $stable(acc_a[LOW_W-1:0]) &&
              $stable(acc_b[ACC_W-1 -: EXT_W]) && $stable(acc_b[LOW_W-1:0])));
  // R4
  other_acc_keep_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (dst_q ? $stable(acc_a) : $stable(acc_b)));
  // R7
  v_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !flags[FV]);
  // R6
  z_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (flags[FZ] == (dmid == '0)));
  // R6
  n_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (flags[FN] == dmid[MID_W-1]));
  // R8
  l_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (flags[FL] == ($past(flags[FL]) | lim_q)));
  // R8
  other_flags_keep_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(flags[FU]) && $stable(flags[FE]) && $stable(flags[FS])));
  // R11
  idle_flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !flag_load) |=> $stable(flags));
  // R11
  idle_acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !acc_load) |=> ($stable(acc_a) && $stable(acc_b)));
endmodule

bind accum_field_rotator arot_chk #(
  .EXT_W(EXT_W), .MID_W(MID_W), .LOW_W(LOW_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .flag_load (flag_load),
  .acc_load  (acc_load),
  .busy      (busy),
  .done      (done),
  .dst_q     (dst_q),
  .lim_q     (lim_q),
  .acc_a     (acc_a),
  .acc_b     (acc_b),
  .flags     (flags)
);

// File: tb/accum_field_rotator_bench.sv
module accum_field_rotator_bench;
  localparam int EXT_W  = 8;
  localparam int MID_W  = 24;
  localparam int LOW_W  = 24;
  localparam int ACC_W  = EXT_W + MID_W + LOW_W;
  localparam int MID_LO = LOW_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst = 1'b1;
  logic             start = 1'b0, dst_sel = 1'b0, rot_right = 1'b0, limit_hit = 1'b0;
  logic             acc_load = 1'b0, acc_load_sel = 1'b0, flag_load = 1'b0;
  logic [ACC_W-1:0] acc_load_val = '0;
  logic [7:0]       flag_load_val = '0;
  logic             busy, done;
  logic [ACC_W-1:0] acc_a, acc_b;
  logic [7:0]       flags;

  accum_field_rotator u_accum_field_rotator (
    .clk(clk), .rst(rst), .start(start), .dst_sel(dst_sel), .rot_right(rot_right),
    .limit_hit(limit_hit), .acc_load(acc_load), .acc_load_sel(acc_load_sel),
    .acc_load_val(acc_load_val), .flag_load(flag_load), .flag_load_val(flag_load_val),
    .busy(busy), .done(done), .acc_a(acc_a), .acc_b(acc_b), .flags(flags)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [ACC_W-1:0] m_acc [2];
  logic [7:0]       m_flg;
  logic [31:0]      seed = 32'h1bad_c0de;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic logic [31:0] rnd();
    seed = nxt(seed);
    return seed;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_acc(input logic sel, input logic [ACC_W-1:0] v);
    @(negedge clk);
    acc_load = 1'b1; acc_load_sel = sel; acc_load_val = v;
    @(negedge clk);
    acc_load = 1'b0;
    m_acc[sel] = v;
    chk("R11 acc load", sel ? acc_b : acc_a, v);
  endtask

  task automatic load_flags(input logic [7:0] v);
    @(negedge clk);
    flag_load = 1'b1; flag_load_val = v;
    @(negedge clk);
    flag_load = 1'b0;
    m_flg = v;
    chk("R11 flag load", flags, v);
  endtask

  task automatic do_rot(input logic dst, input logic dir, input logic lim, input bit disturb);
    logic [MID_W-1:0] mid, res;
    logic             co;
    logic [7:0]       f;
    @(negedge clk);
    start = 1'b1; dst_sel = dst; rot_right = dir; limit_hit = lim;
    @(negedge clk);
    chk("R9 busy after start", {busy, done}, 2'b10);
    if (disturb) begin
      start = 1'b1; dst_sel = ~dst; rot_right = ~dir; limit_hit = ~lim;
      acc_load = 1'b1; acc_load_sel = ~dst; acc_load_val = ~m_acc[~dst];
      flag_load = 1'b1; flag_load_val = ~m_flg;
    end else begin
      start = 1'b0;
    end
    mid = m_acc[dst][MID_LO +: MID_W];
    if (!dir) begin
      res = {mid[MID_W-2:0], m_flg[0]};
      co  = mid[MID_W-1];
    end else begin
      res = {m_flg[0], mid[MID_W-1:1]};
      co  = mid[0];
    end
    f    = m_flg;
    f[0] = co;
    f[1] = 1'b0;
    f[2] = (res == '0);
    f[3] = res[MID_W-1];
    f[6] = m_flg[6] | lim;
    m_acc[dst][MID_LO +: MID_W] = res;
    m_flg = f;
    @(negedge clk);
    start = 1'b0; acc_load = 1'b0; flag_load = 1'b0;
    chk("R9 done pulse", {busy, done}, 2'b01);
    chk(dir ? "R3 R5 rotated field" : "R2 R5 rotated field",
        (dst ? acc_b : acc_a) >> MID_LO & ((64'd1 << MID_W) - 1), res);
    chk("R4 ext/low kept", {(dst ? acc_b : acc_a) >> (MID_LO + MID_W),
        (dst ? acc_b : acc_a) & ((64'd1 << LOW_W) - 1)},
        {m_acc[dst] >> (MID_LO + MID_W), m_acc[dst] & ((64'd1 << LOW_W) - 1)});
    chk("R4 other acc kept", dst ? acc_a : acc_b, m_acc[~dst]);
    chk("R6 N/Z", flags[3:2], f[3:2]);
    chk("R7 V/C", flags[1:0], f[1:0]);
    chk("R8 L sticky, U/E/S kept", flags[7:4], f[7:4]);
    if (disturb) begin
      @(negedge clk);
      chk("R10 restart ignored", {busy, done}, 2'b00);
      chk("R10 acc load ignored A", acc_a, m_acc[0]);
      chk("R10 acc load ignored B", acc_b, m_acc[1]);
      chk("R10 flag load ignored", flags, m_flg);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [MID_W-1:0] pat;
    logic [7:0]       fl;
    m_acc[0] = '0; m_acc[1] = '0; m_flg = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset acc A", acc_a, '0);
    chk("R1 reset acc B", acc_b, '0);
    chk("R1 reset flags", flags, '0);
    chk("R1 reset busy/done", {busy, done}, 2'b00);

    // R12 zero accumulator, carry set, rotate left
    load_flags(8'h01);
    do_rot(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R12 middle field", acc_a[MID_LO +: MID_W], 24'h000001);
    chk("R12 carry cleared", flags[0], 1'b0);

    for (int p = 0; p < 34; p++) begin
      for (int c = 0; c < 16; c++) begin
        if (p < MID_W)       pat = MID_W'(1) << p;
        else if (p == 24)    pat = '0;
        else if (p == 25)    pat = '1;
        else                 pat = MID_W'(rnd());
        load_acc(c[1], {EXT_W'(rnd()), pat, LOW_W'(rnd())});
        load_acc(~c[1], {rnd(), rnd()});
        fl    = 8'(rnd());
        fl[0] = c[2];
        load_flags(fl);
        do_rot(c[1], c[0], c[3], (c == 5 || c == 10) && (p % 4 == 0));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule